// File: doc/BRIEF.md
# Cascaded FIFO Segment Token Controller

This block is the control logic for one storage segment in a ring of segments that together act as one deep first-in first-out buffer. Each segment owns a local write pointer, a local read pointer and an occupancy count. Two tokens circulate around the ring: the write token and the read token. A segment stores incoming words only while it holds the write token, and offers words to the reader only while it holds the read token. When the segment fills its highest location it hands the write token onward. When it drains its highest location it hands the read token onward. The storage array is outside the block: the controller drives its write strobe and both addresses.

Every segment receives the same write strobe and the same read acknowledge. Only the token holder reacts, so one segment at most accepts a word on a given cycle, and one at most releases a word. A strap input chooses the segment that starts with both tokens. The token-out pin of each segment is wired to the token-in pin of the next, and the last segment feeds the first. Each low cycle on that line carries exactly one token. The receiver reads the first token after reset as the write token, the second as the read token, and alternates from then on.

The write side follows valid/ready rules. A word is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the segment lacks the write token or is full, and the source must keep its word until it is taken. The read side follows the same rules. `rd_valid` offers the word at `mem_raddr`, and the word is consumed on a cycle where `rd_ready` is also high. Across the ring, a source simply holds its word through the one-cycle gap while a token is in flight.

Top module: `fifo_ring_seg_ctrl`

## Requirements
- R1: After reset, a segment whose `first_load_n` is 0 holds both tokens (`wr_ready`=1, `rd_oe`=1). A segment whose `first_load_n` is 1 holds neither (`wr_ready`=0, `rd_oe`=0). Every segment starts empty (`empty_n`=0, `full_n`=1, `rd_valid`=0) with `xout_n`=1.
- R2: `wr_ready` is 1 exactly when the segment holds the write token and is not full. `mem_we` is 1 exactly on cycles where `wr_valid` and `wr_ready` are both 1.
- R3: `rd_valid` is 1 exactly when the segment holds the read token and is not empty. `rd_oe` is 1 exactly when the segment holds the read token.
- R4: A write accepted at address DEPTH-1 drives `xout_n` to 0 during the next cycle. From that cycle on, the segment no longer holds the write token.
- R5: A read consumed at address DEPTH-1 drives `xout_n` to 0 during the next cycle. From that cycle on, the segment no longer holds the read token.
- R6: Each cycle in which `xin_n` is 0 grants one token, and the token becomes usable in the following cycle. After reset the first such cycle grants the write token and the second grants the read token, alternating from then on.
- R7: `mem_waddr` and `mem_raddr` are 0 after reset. Each advances by one per accepted write or consumed read, and returns to 0 after address DEPTH-1, which is also the moment its token is given up.
- R8: `full_n` is 0 exactly when DEPTH words are held locally. `empty_n` is 0 exactly when none are held. A write offered while full changes nothing.
- R9: In a ring wired output-to-input, words come out in the order they were accepted, across any number of token passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| first_load_n | input | 1 | Strap: 0 marks the segment that starts with both tokens |
| xin_n | input | 1 | Token-in line from the previous segment, one token per low cycle |
| xout_n | output | 1 | Token-out line to the next segment |
| wr_valid | input | 1 | Write word offered (shared across the ring) |
| wr_ready | output | 1 | This segment accepts the offered word |
| rd_valid | output | 1 | This segment offers the word at `mem_raddr` |
| rd_ready | input | 1 | Reader consumes the offered word (shared across the ring) |
| mem_we | output | 1 | Write strobe to the local storage array |
| mem_waddr | output | $clog2(DEPTH) | Local write address |
| mem_raddr | output | $clog2(DEPTH) | Local read address |
| rd_oe | output | 1 | Read data output enable, high while the read token is held |
| full_n | output | 1 | Local full flag, active low |
| empty_n | output | 1 | Local empty flag, active low |

## Verification
A two-segment ring is driven with one shared write strobe and one shared read acknowledge. A behavioural model is compared with it every cycle, and the bench keeps its own copy of each segment's storage. Four patterns are used:

- A write-only burst fills the ring and keeps offering words. It separates the token hand-off at the top address from the refusal of writes when full.
- A read-only drain separates the read-token passes from the empty stop.
- A strict write-one/read-one rhythm keeps the ring near empty. This makes a write pass and a read pass leave the same segment on adjacent cycles, so it tests that each low cycle carries one token.
- Pseudo-random traffic mixes all of these cases, and order is checked on every word that comes out.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;
  typedef enum logic {
    TOK_WRITE = 1'b0,
    TOK_READ  = 1'b1
  } tok_kind_e;
endpackage

// File: rtl/ring_tok_rx.sv
module ring_tok_rx
  import fifo_ring_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xin_n,
  output logic take_wr,
  output logic take_rd
);
  tok_kind_e expect_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) expect_q <= TOK_WRITE;
    else if (!xin_n) expect_q <= (expect_q == TOK_WRITE) ? TOK_READ : TOK_WRITE;
  end

  assign take_wr = !xin_n && (expect_q == TOK_WRITE);
  assign take_rd = !xin_n && (expect_q == TOK_READ);
endmodule

// File: rtl/ring_seg_ptr.sv
module ring_seg_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          wrap
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  assign wrap = adv && (ptr == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (wrap) ptr <= '0;
    else if (adv)  ptr <= ptr + AW'(1);
  end

  // R7: after the top address the pointer restarts at zero
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == TOP) |=> (ptr == '0));
endmodule

// File: rtl/ring_seg_occ.sv
module ring_seg_occ #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full_n,
  output logic empty_n
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (inc && !dec) count_q <= count_q + CW'(1);
    else if (dec && !inc) count_q <= count_q - CW'(1);
  end

  assign full_n  = (count_q != CAP);
  assign empty_n = (count_q != '0);

  // R8: the gating upstream never pushes a full segment or pops an empty one
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && !dec && count_q == CAP));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec && count_q == '0));
endmodule

// File: rtl/fifo_ring_seg_ctrl.sv
module fifo_ring_seg_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          xin_n,
  output logic          xout_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] mem_raddr,
  output logic          rd_oe,
  output logic          full_n,
  output logic          empty_n
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic wtok_q, rtok_q, xout_q;
  logic take_wr, take_rd;
  logic wr_fire, rd_fire, wr_pass, rd_pass;

  ring_tok_rx u_rx (
    .clk(clk), .rst_n(rst_n), .xin_n(xin_n),
    .take_wr(take_wr), .take_rd(take_rd)
  );

  ring_seg_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_fire), .ptr(mem_waddr), .wrap(wr_pass)
  );

  ring_seg_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_fire), .ptr(mem_raddr), .wrap(rd_pass)
  );

  ring_seg_occ #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(wr_fire), .dec(rd_fire),
    .full_n(full_n), .empty_n(empty_n)
  );

  assign wr_ready = wtok_q && full_n;
  assign rd_valid = rtok_q && empty_n;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign mem_we   = wr_fire;
  assign rd_oe    = rtok_q;
  assign xout_n   = xout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtok_q <= !first_load_n;
      rtok_q <= !first_load_n;
      xout_q <= 1'b1;
    end else begin
      wtok_q <= (wtok_q && !wr_pass) || take_wr;
      rtok_q <= (rtok_q && !rd_pass) || take_rd;
      xout_q <= !(wr_pass || rd_pass);
    end
  end

  // R4: filling the top address emits a token and closes the write side
  assert_pass_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_waddr == TOP) |=> (!xout_n && !wr_ready));
  // R5: draining the top address emits a token and closes the read side
  assert_pass_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && mem_raddr == TOP) |=> (!xout_n && !rd_valid && !rd_oe));
  // R3: data is never offered with the output drivers disabled
  assert_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_oe);
  // R6: an incoming token always lands in one of the two holders
  assert_tok_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xin_n |=> (wtok_q || rtok_q));
endmodule

// File: tb/tb_fifo_ring_seg_ctrl.sv
`timescale 1ns/1ps
module tb_fifo_ring_seg_ctrl;
  localparam int D  = 8;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [1:0] wrdy, rval, roe, xo, fn, en, we;
  logic [AW-1:0] wa [2];
  logic [AW-1:0] ra [2];
  int unsigned wdata = 0;

  always #2 clk = ~clk;

  fifo_ring_seg_ctrl #(.DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b0), .xin_n(xo[1]), .xout_n(xo[0]),
    .wr_valid(wr_valid), .wr_ready(wrdy[0]), .rd_valid(rval[0]), .rd_ready(rd_ready),
    .mem_we(we[0]), .mem_waddr(wa[0]), .mem_raddr(ra[0]), .rd_oe(roe[0]),
    .full_n(fn[0]), .empty_n(en[0]));

  fifo_ring_seg_ctrl #(.DEPTH(D)) dut1 (
    .clk(clk), .rst_n(rst_n), .first_load_n(1'b1), .xin_n(xo[0]), .xout_n(xo[1]),
    .wr_valid(wr_valid), .wr_ready(wrdy[1]), .rd_valid(rval[1]), .rd_ready(rd_ready),
    .mem_we(we[1]), .mem_waddr(wa[1]), .mem_raddr(ra[1]), .rd_oe(roe[1]),
    .full_n(fn[1]), .empty_n(en[1]));

  int checks = 0, fails = 0;
  int mwt[2], mrt[2], mwp[2], mrp[2], mcnt[2], mxo[2], mnx[2];
  int unsigned bmem [2][D];
  int unsigned q[$];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int s = 0; s < 2; s++) begin
      chk($sformatf("R2 R6 wr_ready seg%0d", s), int'(wrdy[s]), int'(mwt[s] != 0 && mcnt[s] < D));
      chk($sformatf("R3 rd_valid seg%0d", s), int'(rval[s]), int'(mrt[s] != 0 && mcnt[s] > 0));
      chk($sformatf("R3 R6 rd_oe seg%0d", s), int'(roe[s]), mrt[s]);
      chk($sformatf("R4 R5 xout_n seg%0d", s), int'(xo[s]), mxo[s]);
      chk($sformatf("R8 full_n seg%0d", s), int'(fn[s]), int'(mcnt[s] != D));
      chk($sformatf("R8 empty_n seg%0d", s), int'(en[s]), int'(mcnt[s] != 0));
      chk($sformatf("R7 mem_waddr seg%0d", s), int'(wa[s]), mwp[s]);
      chk($sformatf("R7 mem_raddr seg%0d", s), int'(ra[s]), mrp[s]);
    end
  endtask

  task automatic step(input bit wv, input bit rr);
    int nwt[2], nrt[2], nwp[2], nrp[2], ncnt[2], nxo[2], nnx[2];
    compare_all();
    wr_valid = wv;
    rd_ready = rr;
    #1;
    for (int s = 0; s < 2; s++) begin
      bit wr_m, rd_m, wl, rl;
      wr_m = wv && mwt[s] != 0 && mcnt[s] < D;
      rd_m = rr && mrt[s] != 0 && mcnt[s] > 0;
      chk($sformatf("R2 mem_we seg%0d", s), int'(we[s]), int'(wr_m));
      if (rval[s] && rr) begin
        int unsigned got, expv;
        got = bmem[s][ra[s]];
        expv = (q.size() > 0) ? q.pop_front() : 32'hDEAD;
        chk($sformatf("R9 read order seg%0d", s), int'(got), int'(expv));
      end
      if (we[s]) begin
        bmem[s][wa[s]] = wdata;
        q.push_back(wdata);
      end
      wl = wr_m && mwp[s] == D - 1;
      rl = rd_m && mrp[s] == D - 1;
      nwt[s] = (mwt[s] != 0 && !wl) ? 1 : 0;
      nrt[s] = (mrt[s] != 0 && !rl) ? 1 : 0;
      nnx[s] = mnx[s];
      if (mxo[1 - s] == 0) begin
        if (mnx[s] != 0) nwt[s] = 1; else nrt[s] = 1;
        nnx[s] = 1 - mnx[s];
      end
      nwp[s]  = wr_m ? (mwp[s] + 1) % D : mwp[s];
      nrp[s]  = rd_m ? (mrp[s] + 1) % D : mrp[s];
      ncnt[s] = mcnt[s] + int'(wr_m) - int'(rd_m);
      nxo[s]  = (wl || rl) ? 0 : 1;
    end
    if (we != 2'b00) wdata++;
    for (int s = 0; s < 2; s++) begin
      mwt[s] = nwt[s]; mrt[s] = nrt[s]; mwp[s] = nwp[s]; mrp[s] = nrp[s];
      mcnt[s] = ncnt[s]; mxo[s] = nxo[s]; mnx[s] = nnx[s];
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      mwt[s] = (s == 0); mrt[s] = (s == 0); mwp[s] = 0; mrp[s] = 0;
      mcnt[s] = 0; mxo[s] = 1; mnx[s] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of the first-load and the follower segment
    chk("R1 seg0 wr_ready", int'(wrdy[0]), 1);
    chk("R1 seg0 rd_oe", int'(roe[0]), 1);
    chk("R1 seg1 wr_ready", int'(wrdy[1]), 0);
    chk("R1 seg1 rd_oe", int'(roe[1]), 0);
    chk("R1 empty_n both", int'(en), 0);
    chk("R1 full_n both", int'(fn), 3);
    chk("R1 rd_valid both", int'(rval), 0);
    chk("R1 xout_n both", int'(xo), 3);
    // fill the whole ring and keep pushing while full (R4, R8)
    repeat (24) step(1'b1, 1'b0);
    chk("R8 ring full seg0", int'(fn[0]), 0);
    chk("R8 ring full seg1", int'(fn[1]), 0);
    // drain everything (R5)
    repeat (24) step(1'b0, 1'b1);
    chk("R8 ring empty", int'(en), 0);
    // flow-through rhythm near empty (R6 back-to-back tokens)
    for (int i = 0; i < 80; i++) step(i % 2 == 0, i % 2 == 1);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
    // pseudo-random traffic (R9)
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[3], lf[5] | (lf[7] & lf[1]));
    end
    repeat (40) step(1'b0, 1'b1);
    chk("R9 queue drained", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule